// File: doc/BRIEF.md
# Console Keyboard and Display Register Controller

This block maps a keyboard and a character display into four word addresses of a 16-bit processor's data space. A read that lands on one of those addresses returns a device register instead of the memory word, and a write to one of them is kept away from memory. The processor tests a ready flag and then moves a character through a data register. It does this by polling, so no interrupt is involved.

On the input side, a character strobe from the keyboard loads an 8-bit code and raises keyboard ready. While that flag is up, further strobes are lost. Reading the keyboard data word takes the character, drops the flag and lets the keyboard deliver again.

On the output side, display ready starts high. A write to the display data word while it is high passes the low byte to the display with a one-cycle valid pulse and drops the flag. The display returns the flag by pulsing its done input.

Top module: `console_mmio_ctrl`

## Requirements
- R1: A read at address 0xFE00 returns keyboard ready in bit 15 and zero in bits 14:0, in place of memory data.
- R2: A keyboard strobe while keyboard ready is 0 stores the code at the clock edge and sets keyboard ready. Address 0xFE02 then reads the code in bits 7:0 and zero in bits 15:8.
- R3: A keyboard strobe while keyboard ready is 1 is discarded: the stored code is unchanged.
- R4: A cycle with the read strobe high at 0xFE02 clears keyboard ready at the clock edge. A keyboard strobe in that same cycle is discarded.
- R5: After synchronous reset, keyboard ready is 0, display ready is 1, both data registers hold zero and the display valid output is 0.
- R6: A write at 0xFE06 while display ready is 1 clears display ready at the clock edge. For one cycle after that edge it drives the display valid output high, with wdata[7:0] on the character output, and 0xFE06 then reads that character.
- R7: A write at 0xFE06 while display ready is 0 is ignored: no valid pulse, and the character is unchanged.
- R8: A display done pulse while display ready is 0 sets display ready at the next clock edge. Address 0xFE04 reads display ready in bit 15 and zero in bits 14:0.
- R9: For any address outside the four device words, read data equals the memory data input and the memory write enable follows the processor write enable.
- R10: For the four device words the memory write enable stays 0, and a write to either status word changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor word address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Read data returned to the processor |
| mem_rdata | input | 16 | Read data from memory |
| mem_we | output | 1 | Write enable passed to memory |
| kbd_strobe | input | 1 | Keyboard has a new character |
| kbd_code | input | 8 | Keyboard character code |
| disp_done | input | 1 | Display finished the last character |
| disp_valid | output | 1 | One-cycle pulse: character sent to display |
| disp_char | output | 8 | Character for the display |

## Verification
Read data and the memory write enable are combinational, so each check on them is made in the same cycle the address is applied, one time step after inputs change at the falling edge. Flag and data-register effects of a strobe, read, write or done pulse take one rising edge, so they are observed through the status and data words in the following vector. The display valid pulse is likewise checked in the cycle right after the accepting edge, and again one cycle later to confirm it has ended.

// File: rtl/console_mmio_ctrl.sv
module console_mmio_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] KSTAT_A = 16'hFE00,
  parameter logic [AW-1:0] KDATA_A = 16'hFE02,
  parameter logic [AW-1:0] DSTAT_A = 16'hFE04,
  parameter logic [AW-1:0] DDATA_A = 16'hFE06
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  input  logic          kbd_strobe,
  input  logic [CW-1:0] kbd_code,
  input  logic          disp_done,
  output logic          disp_valid,
  output logic [CW-1:0] disp_char
);
  localparam int PAD = DW - CW;
  localparam int LOW = DW - 1;

  logic          kbd_rdy, disp_rdy;
  logic [CW-1:0] kbd_data;

  wire hit_ks = (cpu_addr == KSTAT_A);
  wire hit_kd = (cpu_addr == KDATA_A);
  wire hit_ds = (cpu_addr == DSTAT_A);
  wire hit_dd = (cpu_addr == DDATA_A);
  wire dev_hit = hit_ks | hit_kd | hit_ds | hit_dd;

  wire kd_take  = cpu_rd & hit_kd;
  wire kd_load  = kbd_strobe & ~kbd_rdy & ~kd_take;
  wire dd_write = cpu_we & hit_dd;
  wire dd_take  = dd_write & disp_rdy;

  assign mem_we = cpu_we & ~dev_hit;

  always_comb begin
    unique case (1'b1)
      hit_ks:  cpu_rdata = {kbd_rdy, {LOW{1'b0}}};
      hit_kd:  cpu_rdata = {{PAD{1'b0}}, kbd_data};
      hit_ds:  cpu_rdata = {disp_rdy, {LOW{1'b0}}};
      hit_dd:  cpu_rdata = {{PAD{1'b0}}, disp_char};
      default: cpu_rdata = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kbd_rdy  <= 1'b0;
      kbd_data <= '0;
    end else if (kd_load) begin
      kbd_rdy  <= 1'b1;
      kbd_data <= kbd_code;
    end else if (kd_take) begin
      kbd_rdy  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_rdy   <= 1'b1;
      disp_char  <= '0;
      disp_valid <= 1'b0;
    end else begin
      disp_valid <= dd_take;
      if (dd_take) begin
        disp_rdy  <= 1'b0;
        disp_char <= cpu_wdata[CW-1:0];
      end else if (disp_done) begin
        disp_rdy  <= 1'b1;
      end
    end
  end

  assert_kbd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (kbd_rdy && !kd_take) |=> (kbd_rdy && $stable(kbd_data)));

  assert_kbd_clear_R4: assert property (@(posedge clk) disable iff (rst)
    kd_take |=> !kbd_rdy);

  assert_disp_take_R6: assert property (@(posedge clk) disable iff (rst)
    (dd_write && disp_rdy) |=> (disp_valid && !disp_rdy));

  assert_disp_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (!disp_rdy && !disp_done) |=> (!disp_valid && $stable(disp_char)));

  assert_disp_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (disp_done && !disp_rdy) |=> disp_rdy);
endmodule

// File: tb/sim_console_mmio_ctrl.sv
module sim_console_mmio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [15:0] mem_rdata = 16'hA5C3;
  logic        mem_we;
  logic        kbd_strobe = 1'b0;
  logic [7:0]  kbd_code = '0;
  logic        disp_done = 1'b0;
  logic        disp_valid;
  logic [7:0]  disp_char;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  console_mmio_ctrl u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .kbd_strobe(kbd_strobe), .kbd_code(kbd_code),
    .disp_done(disp_done), .disp_valid(disp_valid), .disp_char(disp_char)
  );

  // {addr, rd, we, wdata, strobe, code, done, exp_rdata, exp_mem_we, exp_valid}
  localparam int NV = 19;
  localparam logic [61:0] VEC [NV] = '{
    {16'hFE00,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h0000,1'b0,1'b0},
    {16'hFE04,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h8000,1'b0,1'b0},
    {16'h3000,1'b1,1'b1,16'h1234,1'b0,8'h00,1'b0,16'hA5C3,1'b1,1'b0},
    {16'h3000,1'b0,1'b0,16'h0000,1'b1,8'h41,1'b0,16'hA5C3,1'b0,1'b0},
    {16'hFE00,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h8000,1'b0,1'b0},
    {16'hFE02,1'b0,1'b0,16'h0000,1'b1,8'h42,1'b0,16'h0041,1'b0,1'b0},
    {16'hFE02,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h0041,1'b0,1'b0},
    {16'hFE00,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h0000,1'b0,1'b0},
    {16'hFE02,1'b1,1'b0,16'h0000,1'b1,8'h43,1'b0,16'h0041,1'b0,1'b0},
    {16'hFE00,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h0000,1'b0,1'b0},
    {16'hFE02,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h0041,1'b0,1'b0},
    {16'hFE00,1'b0,1'b1,16'hFFFF,1'b0,8'h00,1'b0,16'h0000,1'b0,1'b0},
    {16'hFE00,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h0000,1'b0,1'b0},
    {16'hFE06,1'b0,1'b1,16'h1258,1'b0,8'h00,1'b0,16'h0000,1'b0,1'b0},
    {16'hFE04,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h0000,1'b0,1'b1},
    {16'hFE06,1'b0,1'b1,16'h0077,1'b0,8'h00,1'b0,16'h0058,1'b0,1'b0},
    {16'hFE06,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h0058,1'b0,1'b0},
    {16'hFE04,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b1,16'h0000,1'b0,1'b0},
    {16'hFE04,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0,16'h8000,1'b0,1'b0}
  };
  string tags [NV] = '{"R1","R5","R9","R9","R2","R3","R3","R4","R4","R4",
                       "R3","R10","R10","R6","R6","R7","R7","R8","R8"};

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic rd, input logic we,
                       input logic [15:0] wd, input logic stb, input logic [7:0] code,
                       input logic done);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_we = we; cpu_wdata = wd;
    kbd_strobe = stb; kbd_code = code; disp_done = done;
    #1;
  endtask

  task automatic look(input logic [15:0] a, input string req, input logic [15:0] exp);
    drive(a, 1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 1'b0);
    check(req, "rdata", cpu_rdata, exp);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][61:46], VEC[i][45], VEC[i][44], VEC[i][43:28],
            VEC[i][27], VEC[i][26:19], VEC[i][18]);
      check(tags[i], "rdata", cpu_rdata, VEC[i][17:2]);
      check(tags[i], "mem_we", {15'b0, mem_we}, {15'b0, VEC[i][1]});
      check(tags[i], "disp_valid", {15'b0, disp_valid}, {15'b0, VEC[i][0]});
    end
    // R6: character output carries the accepted byte, not the rejected one
    check("R6", "disp_char", {8'h00, disp_char}, 16'h0058);

    // R6: write accepted when done arrives in the same cycle; pulse lasts one cycle
    drive(16'hFE06, 1'b0, 1'b1, 16'hAA33, 1'b0, 8'h00, 1'b1);
    look(16'hFE04, "R6", 16'h0000);
    check("R6", "disp_valid", {15'b0, disp_valid}, 16'h0001);
    check("R6", "disp_char", {8'h00, disp_char}, 16'h0033);
    look(16'hFE06, "R6", 16'h0033);
    check("R6", "disp_valid end", {15'b0, disp_valid}, 16'h0000);

    // R10: status write while display busy does not set ready
    drive(16'hFE04, 1'b0, 1'b1, 16'hFFFF, 1'b0, 8'h00, 1'b0);
    check("R10", "mem_we", {15'b0, mem_we}, 16'h0000);
    look(16'hFE04, "R10", 16'h0000);

    // R2: fresh capture after re-arm, upper byte zero
    drive(16'h0100, 1'b0, 1'b0, 16'h0000, 1'b1, 8'hFE, 1'b0);
    look(16'hFE02, "R2", 16'h00FE);
    look(16'hFE00, "R2", 16'h8000);

    // R5: reset from a dirty state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R5", "disp_valid", {15'b0, disp_valid}, 16'h0000);
    look(16'hFE00, "R5", 16'h0000);
    look(16'hFE02, "R5", 16'h0000);
    look(16'hFE04, "R5", 16'h8000);
    look(16'hFE06, "R5", 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule